// File: doc/BRIEF.md
# Cross Trigger Routing Matrix

This block is a register-programmed event router. Trigger inputs are routed onto a small set of shared channels, and the channels are then routed onto trigger outputs. Each input has a mask that selects the channels it drives. Each output has a mask that selects the channels that fire it. Software can also hold channels active, release them, or pulse them for a single cycle.

A trigger output latches when it fires. It stays high, for example as an interrupt request, until software acknowledges that bit. Live levels of the inputs, outputs and channels can be read back. A key-based lock guards every configuration write. The unit comes out of reset locked, so software must write the key before any setting takes effect.

The register bus uses one cycle per access. Each address selects a 32-bit word. Read data appears on the clock after the request.

Top module: `xtrig_matrix`

## Requirements
- R1: After reset the unit is locked and disabled, all channel masks and software-held channels are zero, and every trigger output is low.
- R2: Writing 0xC5ACCE55 to byte offset 0xFB0 unlocks the unit. Writing any other value there locks it. Offset 0xFB4 reads bit 0 = 1 when locked and bit 1 = 1 at all times.
- R3: While the unit is locked, writes to any offset other than 0xFB0 change nothing.
- R4: Bit 0 of offset 0x000 is the global enable. It reads back as written.
- R5: The channel mask of input n is at offset 0x020+4n, and the channel mask of output m is at offset 0x0A0+4m. Bit c of a mask is channel c, and only the low 4 bits are stored. A read returns its data on the clock after the request.
- R6: A channel is active when an enabled input mapped to it is high, when software holds it, or when it is pulsed. Output m latches high on the clock after any active channel is also set in output m's mask while the global enable is 1.
- R7: A latched output stays high until a 1 is written to bit m of offset 0x010. If output m fires in the same cycle as the acknowledge, the output stays set.
- R8: While the global enable is 0, no output becomes newly latched.
- R9: Writing to offset 0x014 holds the channels given by the 1 bits of the data. Writing to offset 0x018 releases the channels given by the 1 bits. Reading 0x014 returns the held set.
- R10: Writing to offset 0x01C makes the channels given by the 1 bits of the data active for exactly one cycle, starting on the clock after the write.
- R11: Offsets 0x130, 0x134, 0x138 and 0x13C return the live trigger inputs, the latched outputs, the channel states driven by inputs, and the full channel states.
- R12: Reads of offsets with no register, and of the write-only offsets 0x010, 0x018 and 0x01C, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid on the clock after the request |
| trig_in | input | N_IN (8) | Trigger event inputs |
| trig_out | output | N_OUT (8) | Latched trigger outputs |

## Verification
The bench builds the block with its default sizes: eight inputs, eight outputs and four channels. With these sizes, one input can drive two channels at once. One output can have all four channel bits set, so it fires alongside the outputs under test and shows that fan-out and overlap are handled. A mask write of all ones shows that only the four channel bits are stored. Eight outputs fill the acknowledge field, so a full-width acknowledge can be tested against a software-held channel that keeps firing in the same cycle.

// File: rtl/xtrig_matrix.sv
module xtrig_matrix #(
  parameter int          N_IN  = 8,
  parameter int          N_OUT = 8,
  parameter int          N_CH  = 4,
  parameter logic [31:0] KEY   = 32'hC5ACCE55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [N_IN-1:0]  trig_in,
  output logic [N_OUT-1:0] trig_out
);
  localparam logic [9:0] A_CTRL  = 10'h000;
  localparam logic [9:0] A_ACK   = 10'h004;
  localparam logic [9:0] A_SET   = 10'h005;
  localparam logic [9:0] A_CLR   = 10'h006;
  localparam logic [9:0] A_PUL   = 10'h007;
  localparam logic [9:0] A_INEN  = 10'h008;
  localparam logic [9:0] A_OUTEN = 10'h028;
  localparam logic [9:0] A_TIS   = 10'h04C;
  localparam logic [9:0] A_TOS   = 10'h04D;
  localparam logic [9:0] A_CIS   = 10'h04E;
  localparam logic [9:0] A_COS   = 10'h04F;
  localparam logic [9:0] A_LAR   = 10'h3EC;
  localparam logic [9:0] A_LSR   = 10'h3ED;

  logic [9:0]       waddr;
  logic             locked_q, en_q;
  logic [N_CH-1:0]  in_mask  [N_IN];
  logic [N_CH-1:0]  out_mask [N_OUT];
  logic [N_CH-1:0]  sw_set_q, pulse_q, chan_in, chan_out;
  logic [N_OUT-1:0] trig_q, hit, ack_bits;
  logic             lar_wr, cfg_wr, pul_wr;
  logic [31:0]      rd_next;

  assign waddr    = bus_addr[11:2];
  assign lar_wr   = bus_sel & bus_wr & (waddr == A_LAR);
  assign cfg_wr   = bus_sel & bus_wr & ~locked_q & (waddr != A_LAR);
  assign pul_wr   = cfg_wr & (waddr == A_PUL);
  assign ack_bits = (cfg_wr && waddr == A_ACK) ? bus_wdata[N_OUT-1:0] : '0;
  assign trig_out = trig_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) locked_q <= 1'b1;
    else if (lar_wr) locked_q <= (bus_wdata != KEY);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= 1'b0;
    else if (cfg_wr && waddr == A_CTRL) en_q <= bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sw_set_q <= '0;
    else if (cfg_wr && waddr == A_SET) sw_set_q <= sw_set_q | bus_wdata[N_CH-1:0];
    else if (cfg_wr && waddr == A_CLR) sw_set_q <= sw_set_q & ~bus_wdata[N_CH-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pulse_q <= '0;
    else pulse_q <= pul_wr ? bus_wdata[N_CH-1:0] : '0;

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) in_mask[gi] <= '0;
      else if (cfg_wr && waddr == 10'(A_INEN + gi)) in_mask[gi] <= bus_wdata[N_CH-1:0];
  end

  for (genvar go = 0; go < N_OUT; go++) begin : g_out
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) out_mask[go] <= '0;
      else if (cfg_wr && waddr == 10'(A_OUTEN + go)) out_mask[go] <= bus_wdata[N_CH-1:0];
    assign hit[go] = en_q & |(chan_out & out_mask[go]);
  end

  always_comb begin
    chan_in = '0;
    for (int n = 0; n < N_IN; n++)
      if (trig_in[n]) chan_in = chan_in | in_mask[n];
  end
  assign chan_out = chan_in | sw_set_q | pulse_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) trig_q <= '0;
    else trig_q <= (trig_q & ~ack_bits) | hit;

  always_comb begin
    rd_next = '0;
    case (waddr)
      A_CTRL: rd_next[0]        = en_q;
      A_SET:  rd_next[N_CH-1:0] = sw_set_q;
      A_TIS:  rd_next[N_IN-1:0] = trig_in;
      A_TOS:  rd_next[N_OUT-1:0] = trig_q;
      A_CIS:  rd_next[N_CH-1:0] = chan_in;
      A_COS:  rd_next[N_CH-1:0] = chan_out;
      A_LSR:  rd_next[1:0]      = {1'b1, locked_q};
      default: ;
    endcase
    for (int n = 0; n < N_IN; n++)
      if (waddr == 10'(A_INEN + n)) rd_next[N_CH-1:0] = in_mask[n];
    for (int m = 0; m < N_OUT; m++)
      if (waddr == 10'(A_OUTEN + m)) rd_next[N_CH-1:0] = out_mask[m];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_next;

  AST_UNLOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (lar_wr && bus_wdata == KEY) |=> !locked_q); // R2
  AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (lar_wr && bus_wdata != KEY) |=> locked_q); // R2
  AST_LOCKED_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && bus_sel && bus_wr && waddr == A_CTRL) |=> $stable(en_q)); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_bits == '0) |=> ((trig_q & $past(trig_q)) == $past(trig_q))); // R7
  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> ((trig_q & ~$past(trig_q)) == '0)); // R8
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0 && !pul_wr) |=> (pulse_q == '0)); // R10
endmodule

// File: tb/test_xtrig_matrix.sv
module test_xtrig_matrix;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0]  trig_in = '0, trig_out;
  int tests = 0, fails = 0;
  localparam logic [31:0] KEY = 32'hC5ACCE55;

  xtrig_matrix i_xtrig_matrix (.clk, .rst_n, .bus_sel, .bus_wr, .bus_addr,
    .bus_wdata, .bus_rdata, .trig_in, .trig_out);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    chk("R1 outputs", 32'(trig_out), 0);
    rd_chk(12'hFB4, 3, "R1 R2 lock status");
    rd_chk(12'h000, 0, "R1 enable");
    rd_chk(12'h02C, 0, "R1 in mask");
  endtask

  task automatic t_locked;
    wr(12'h000, 1);
    wr(12'h020, 32'hF);
    rd_chk(12'h000, 0, "R3 ctrl locked");
    rd_chk(12'h020, 0, "R3 mask locked");
  endtask

  task automatic t_unlock_masks;
    wr(12'hFB0, KEY);
    rd_chk(12'hFB4, 2, "R2 unlocked");
    wr(12'h02C, 5);
    wr(12'h0B8, 4);
    wr(12'h0BC, 32'hFFFFFFFF);
    rd_chk(12'h02C, 5, "R5 in mask 3");
    rd_chk(12'h0B8, 4, "R5 out mask 6");
    rd_chk(12'h0BC, 32'hF, "R5 width");
  endtask

  task automatic t_route;
    wr(12'h000, 1);
    rd_chk(12'h000, 1, "R4 enable");
    trig_in = 8'h08;
    @(negedge clk);
    trig_in = 0;
    chk("R6 route", 32'(trig_out), 32'hC0);
    repeat (2) @(negedge clk);
    chk("R7 hold", 32'(trig_out), 32'hC0);
    rd_chk(12'h134, 32'hC0, "R11 out status");
  endtask

  task automatic t_ack;
    wr(12'h010, 32'h40);
    chk("R7 ack one", 32'(trig_out), 32'h80);
    wr(12'h010, 32'h80);
    chk("R7 ack all", 32'(trig_out), 0);
  endtask

  task automatic t_status;
    trig_in = 8'h08;
    rd_chk(12'h130, 32'h08, "R11 in status");
    rd_chk(12'h138, 32'h5, "R11 chan in");
    rd_chk(12'h13C, 32'h5, "R11 chan out");
    trig_in = 0;
    wr(12'h010, 32'hFF);
    chk("R7 cleared", 32'(trig_out), 0);
  endtask

  task automatic t_disable;
    wr(12'h000, 0);
    trig_in = 8'h08;
    repeat (2) @(negedge clk);
    chk("R8 disabled", 32'(trig_out), 0);
    rd_chk(12'h138, 32'h5, "R11 chan while disabled");
    trig_in = 0;
    wr(12'h000, 1);
    @(negedge clk);
    chk("R8 no late fire", 32'(trig_out), 0);
  endtask

  task automatic t_swset;
    wr(12'h0A8, 2);
    wr(12'h014, 2);
    @(negedge clk);
    chk("R9 set fires", 32'(trig_out), 32'h84);
    rd_chk(12'h014, 2, "R9 set readback");
    rd_chk(12'h13C, 2, "R11 chan out sw");
    wr(12'h010, 32'hFF);
    chk("R7 ack loses to fire", 32'(trig_out), 32'h84);
    wr(12'h018, 2);
    wr(12'h010, 32'hFF);
    chk("R9 clear", 32'(trig_out), 0);
    rd_chk(12'h014, 0, "R9 set empty");
  endtask

  task automatic t_pulse;
    wr(12'h0B4, 1);
    wr(12'h01C, 1);
    chk("R10 not yet", 32'(trig_out), 0);
    @(negedge clk);
    chk("R10 pulse fires", 32'(trig_out), 32'hA0);
    rd_chk(12'h13C, 0, "R10 pulse gone");
    wr(12'h010, 32'hFF);
    @(negedge clk);
    chk("R10 single", 32'(trig_out), 0);
  endtask

  task automatic t_unimpl;
    rd_chk(12'h100, 0, "R12 hole");
    rd_chk(12'hFE0, 0, "R12 high hole");
    rd_chk(12'h010, 0, "R12 ack reads 0");
    rd_chk(12'h01C, 0, "R12 pulse reads 0");
  endtask

  task automatic t_relock;
    wr(12'hFB0, ~KEY);
    rd_chk(12'hFB4, 3, "R2 relock");
    wr(12'h000, 0);
    rd_chk(12'h000, 1, "R3 ctrl kept");
    wr(12'h014, 1);
    @(negedge clk);
    chk("R3 set ignored", 32'(trig_out), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_locked;
    t_unlock_masks;
    t_route;
    t_ack;
    t_status;
    t_disable;
    t_swset;
    t_pulse;
    t_unimpl;
    t_relock;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule